// File: doc/BRIEF.md
# Isolate-and-Recheck Test Controller

This controller sharpens the suspect map produced by a statistical fault localizer on a bundle of vertical interconnect wires, and it does so while the bundle keeps carrying traffic. The wires form a grid of `ROWS` by `COLS` positions. Each position has one bit in the masks, at bit index `row*COLS + col`. The controller drives an isolation mask: an isolated wire still carries data, but the parity code ignores it on both the encode side and the decode side. The controller starts localizer windows with a one-cycle pulse and reads the suspect map that comes back with each window's done flag.

A run has two phases. In the first phase the controller runs windows until one of them reports no position that is not already isolated. Every new suspect is added to the fault map and to the isolation mask. In the second phase the controller visits the suspects in ascending bit order. For each one it takes that single wire out of isolation and runs one more window. An all-zero report clears the wire as healthy; any other report keeps it as faulty. The wire then goes back into isolation. A cycle budget, captured when the run starts, bounds the whole run. When the budget runs out, the controller stops and keeps the map it has so far.

Top module: `isolate_recheck_ctrl`

## Requirements
- R1: After reset, busy, timeout and the localizer start pulse are low, and the fault map and isolation mask are all zero.
- R2: A start request while idle clears the fault map, the isolation mask and the timeout flag, and captures the budget. From the next clock edge, busy is high and the localizer start pulse is high for exactly that first busy cycle. Every localizer start is a single-cycle pulse.
- R3: In the first phase, each window whose report has bits outside the isolation mask ORs those bits into both the fault map and the isolation mask, then launches another window.
- R4: The first phase ends on the first window that reports no position outside the isolation mask, including an all-zero report.
- R5: In the second phase, suspects are released in ascending bit order (row-major, bit = row*COLS + col). Exactly one position is out of isolation during each re-test window, and every suspect gets exactly one re-test window.
- R6: A re-test whose report is all zero removes the released position from the fault map; any other report keeps it. In both cases the position is put back into the isolation mask, and no bit is ever added to the fault map in the second phase.
- R7: On normal completion, busy falls, timeout stays low, the fault map is a subset of the isolation mask, and both stay constant until the next start.
- R8: Busy lasts at most budget+1 cycles. When the budget is reached, busy falls, the fault map keeps its value, every fault bit is isolated, and timeout is high until the next start.
- R9: A start request while busy has no effect on the run, and a localizer done flag while idle changes neither the fault map nor the isolation mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run request, honoured only when idle |
| budget_i | input | CNT_W | Cycle budget, captured at start |
| loc_done_i | input | 1 | Localizer window finished, report valid |
| loc_map_i | input | ROWS*COLS | Localizer suspect report |
| iso_mask_o | output | ROWS*COLS | Wires excluded from parity encode and decode |
| loc_start_o | output | 1 | One-cycle localizer window launch |
| fault_map_o | output | ROWS*COLS | Confirmed fault map |
| busy_o | output | 1 | Run in progress |
| timeout_o | output | 1 | Last run was stopped by the budget |

## Verification
A wrong internal state shows at the ports within one localizer window. A bad release index puts the wrong bit, or two bits, outside isolation on the next launch pulse. A failure to restore a released bit shows in the final mask, because it no longer covers the fault map. A wrong verdict in the second phase shows as a final fault map that differs from the faulty set the localizer model holds. A stuck or miscounted phase shows in the number of launch pulses, which must equal two plus the number of suspects when any suspect exists. A budget counter that is off shows as a busy width that differs from budget+1 in the timeout case.

// File: rtl/isolate_recheck_ctrl.sv
module isolate_recheck_ctrl #(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       budget_i,
  input  logic                   loc_done_i,
  input  logic [ROWS*COLS-1:0]   loc_map_i,
  output logic [ROWS*COLS-1:0]   iso_mask_o,
  output logic                   loc_start_o,
  output logic [ROWS*COLS-1:0]   fault_map_o,
  output logic                   busy_o,
  output logic                   timeout_o
);
  localparam int N  = ROWS * COLS;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ISO_GO, S_ISO_WAIT, S_SCAN, S_REL_GO, S_REL_WAIT} st_t;

  st_t              st;
  logic [IW-1:0]    idx;
  logic [CNT_W-1:0] cnt, bud;
  logic [N-1:0]     fault, iso;
  logic             tmo;

  wire [N-1:0] fresh   = loc_map_i & ~iso;
  wire         last    = (idx == IW'(N - 1));
  wire         rel_ph  = (st == S_SCAN) || (st == S_REL_GO) || (st == S_REL_WAIT);

  assign iso_mask_o  = iso;
  assign fault_map_o = fault;
  assign busy_o      = (st != S_IDLE);
  assign timeout_o   = tmo;
  assign loc_start_o = (st == S_ISO_GO) || (st == S_REL_GO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      cnt   <= '0;
      bud   <= '0;
      fault <= '0;
      iso   <= '0;
      tmo   <= 1'b0;
    end else if (st == S_IDLE) begin
      if (start_i) begin
        st    <= S_ISO_GO;
        fault <= '0;
        iso   <= '0;
        cnt   <= '0;
        bud   <= budget_i;
        tmo   <= 1'b0;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == bud) begin
        st  <= S_IDLE;
        tmo <= 1'b1;
        iso <= iso | fault;
      end else begin
        case (st)
          S_ISO_GO: st <= S_ISO_WAIT;
          S_ISO_WAIT:
            if (loc_done_i) begin
              if (fresh == '0) begin
                st  <= S_SCAN;
                idx <= '0;
              end else begin
                fault <= fault | fresh;
                iso   <= iso | fresh;
                st    <= S_ISO_GO;
              end
            end
          S_SCAN:
            if (fault[idx]) begin
              iso[idx] <= 1'b0;
              st       <= S_REL_GO;
            end else if (last) begin
              st <= S_IDLE;
            end else begin
              idx <= idx + IW'(1);
            end
          S_REL_GO: st <= S_REL_WAIT;
          S_REL_WAIT:
            if (loc_done_i) begin
              if (loc_map_i == '0) fault[idx] <= 1'b0;
              iso[idx] <= 1'b1;
              if (last) st <= S_IDLE;
              else begin
                idx <= idx + IW'(1);
                st  <= S_SCAN;
              end
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loc_start_o |=> !loc_start_o);

  assert_single_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fault_map_o & ~iso_mask_o) <= 1);

  assert_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ph && $past(rel_ph)) |-> ((fault_map_o & ~$past(fault_map_o)) == '0));

  assert_final_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ((fault_map_o & ~iso_mask_o) == '0));

  assert_budget_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt == bud) |=> (!busy_o && timeout_o));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(fault_map_o) && $stable(iso_mask_o)));
endmodule

// File: tb/isolate_recheck_ctrl_tb.sv
module isolate_recheck_ctrl_tb;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [15:0]   budget_i = '0;
  logic          loc_done_i = 1'b0;
  logic [N-1:0]  loc_map_i = '0;
  logic [N-1:0]  iso_mask_o, fault_map_o;
  logic          loc_start_o, busy_o, timeout_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  isolate_recheck_ctrl #(.ROWS(4), .COLS(8), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .budget_i(budget_i),
    .loc_done_i(loc_done_i), .loc_map_i(loc_map_i), .iso_mask_o(iso_mask_o),
    .loc_start_o(loc_start_o), .fault_map_o(fault_map_o), .busy_o(busy_o),
    .timeout_o(timeout_o));

  // columns: true faults, first-window false alarms, poke while busy, expected fault map
  localparam int NV = 5;
  localparam logic [N-1:0] V_TRUE [NV] = '{32'h0, 32'h0000_0001, 32'h8000_0100, 32'h0, 32'hFFFF_FFFF};
  localparam logic [N-1:0] V_FP   [NV] = '{32'h0, 32'h0, 32'h0010_0000, 32'h0000_00F0, 32'h0};
  localparam bit           V_POKE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [N-1:0] V_EXP  [NV] = '{32'h0, 32'h0000_0001, 32'h8000_0100, 32'h0, 32'hFFFF_FFFF};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [N-1:0] tru, input logic [N-1:0] fp, input logic [15:0] bud,
                     input bit poke, output int starts, output int bcyc, output bit order_ok);
    int cd = 0;
    int win = 0;
    int prev = -1;
    logic [N-1:0] rel;
    @(negedge clk);
    start_i  = 1'b1;
    budget_i = bud;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && loc_start_o && fault_map_o == '0 && iso_mask_o == '0 && !timeout_o,
          "R2 start", {busy_o, loc_start_o, timeout_o}, 3'b110);
    starts = 0; bcyc = 0; order_ok = 1'b1;
    for (int k = 0; k < 20000 && busy_o; k++) begin
      bcyc++;
      if (loc_done_i) begin loc_done_i = 1'b0; loc_map_i = '0; end
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          loc_done_i = 1'b1;
          loc_map_i  = (tru & ~iso_mask_o) | ((win == 1) ? (fp & ~iso_mask_o) : '0);
        end
      end
      if (loc_start_o) begin
        starts++; win++; cd = 3;
        rel = fault_map_o & ~iso_mask_o;
        if (rel != '0) begin
          if ($countones(rel) != 1) order_ok = 1'b0;
          for (int b = 0; b < N; b++) if (rel[b]) begin
            if (b <= prev) order_ok = 1'b0;
            prev = b;
          end
        end
      end
      if (poke && k == 4) begin start_i = 1'b1; budget_i = 16'd1; end
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0; loc_done_i = 1'b0; loc_map_i = '0;
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int starts, bcyc, exp_starts;
    bit order_ok;
    logic [N-1:0] f0, i0;
    repeat (3) @(negedge clk);
    check(!busy_o && !timeout_o && !loc_start_o && fault_map_o == '0 && iso_mask_o == '0,
          "R1 reset", {busy_o, timeout_o, loc_start_o}, 3'b000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run(V_TRUE[v], V_FP[v], 16'd1000, V_POKE[v], starts, bcyc, order_ok);
      exp_starts = ((V_TRUE[v] | V_FP[v]) != '0) ? 2 + $countones(V_TRUE[v] | V_FP[v]) : 1;
      check(fault_map_o == V_EXP[v], "R6 final fault map", fault_map_o, V_EXP[v]);
      check(iso_mask_o == (V_TRUE[v] | V_FP[v]), "R3 isolation covers all suspects", iso_mask_o, V_TRUE[v] | V_FP[v]);
      check(starts == exp_starts, "R4 window count", starts, exp_starts);
      check(order_ok, "R5 ascending single release", order_ok, 1);
      check(!busy_o && !timeout_o, "R7 normal completion", {busy_o, timeout_o}, 2'b00);
      if (V_POKE[v]) check(!timeout_o && fault_map_o == V_EXP[v], "R9 start while busy ignored", timeout_o, 0);
    end

    run(32'h0000_0003, 32'h0, 16'd2, 1'b0, starts, bcyc, order_ok);
    check(timeout_o, "R8 timeout flag", timeout_o, 1);
    check(bcyc == 3, "R8 busy width budget+1", bcyc, 3);
    check(fault_map_o == '0 && iso_mask_o == '0, "R8 map kept", fault_map_o, 0);
    repeat (3) @(negedge clk);
    check(timeout_o && !busy_o, "R8 timeout held while idle", timeout_o, 1);

    f0 = fault_map_o; i0 = iso_mask_o;
    loc_done_i = 1'b1; loc_map_i = '1;
    @(negedge clk);
    loc_done_i = 1'b0; loc_map_i = '0;
    @(negedge clk);
    check(fault_map_o == f0 && iso_mask_o == i0 && !busy_o, "R9 idle done ignored", fault_map_o, f0);

    run(32'h0000_0400, 32'h0, 16'd1000, 1'b0, starts, bcyc, order_ok);
    check(!timeout_o && fault_map_o == 32'h0000_0400, "R8 timeout cleared by new start", fault_map_o, 32'h0000_0400);
    check(bcyc <= 1001, "R8 busy within budget", bcyc, 1001);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule